// File: doc/BRIEF.md
# Limit-Match Counter Timer

This block is a memory-mapped counter/timer. An external enable strobe marks each tick, and every tick adds one to a count field that sits in bits 30:9 of a 32-bit word. Bits 8:0 of that word always read zero. The count is compared against a programmable limit. When the next count value would equal a non-zero limit, the count returns to zero on that tick. The same tick sets a sticky reached flag and raises a level interrupt. Software acknowledges the interrupt by reading the limit register.

A limit of zero puts the block into free-running mode. In that mode the count runs through the whole field and wraps, never sets the flag and never raises the interrupt. A second limit port changes the compare value without restarting the count, so a period can be retuned while the counter is running.

The register interface is a synchronous 32-bit port with a word address, a write strobe and a read strobe. Read data appears one clock after the strobe. The tick prescaler, the bus bridge and the routing of the interrupt belong to the surrounding logic.

Top module: `limit_match_timer`

## Requirements
- R1: After synchronous reset the limit is 0, the count is 0, the reached flag is clear and `irq` is low. The counter then runs freely.
- R2: The count field occupies bits [9 +: CNT_W] of the count word. Each clock with `tick_en` high adds one to that field. Bits 8:0 always read zero. Without `tick_en` the count holds.
- R3: With a non-zero limit L, the tick that would bring the count to L clears the count to 0 instead. That same tick sets the reached flag (bit 31 of the count word) and raises `irq`. The period is therefore L ticks.
- R4: With a limit of 0, the count returns to zero on the tick that would make the field all ones. The reached flag and `irq` never rise in this mode.
- R5: A write to word offset 0 stores `wdata` masked to the count field, restarts the count at 0 and drops `irq`. The reached flag is left unchanged. The write takes precedence over a tick in the same cycle.
- R6: A read of word offset 0 returns the stored limit in bits [9 +: CNT_W]; all other bits are 0, including bit 31. The same read clears the reached flag and drops `irq`. A match on the same cycle still sets both.
- R7: A read of word offset 1 returns the count field OR-ed with the reached flag in bit 31. Writes to offset 1 change nothing.
- R8: A write to word offset 2 replaces the limit but leaves the count running. If the new limit is at or below the count, the count runs on to the top of the field, wraps to 0 without a match, and then matches at the new limit.
- R9: Reads of word offsets 3 and above return zero. Writes to those offsets change nothing.
- R10: `rdata` holds the value selected by the address on the strobe cycle, starting the cycle after `rd_en`. It keeps that value until the next read.
- R11: `irq` is a level. Once raised it stays high until an offset-0 read or an offset-0 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count enable from the external prescaler |
| addr | input | ADDR_W | Word offset of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt on limit match |

## Verification
A wrong count or limit register shows up as a period that is off by ticks. The sweep catches it at the first offset-1 read after the expected match point, which means within one period of the programmed limit. A flag that clears or sets wrongly shows in bit 31 of the next count read, or on `irq`, in the cycle after the event. That is why the bench reads back right after each match, acknowledge and limit write. The sweep covers every non-zero limit of a 6-bit count field, together with free-run wrap, a mid-count limit change above and below the count, and an acknowledge that collides with a match.

// File: rtl/lmt_pkg.sv
package lmt_pkg;

    localparam int WORD_W   = 32;
    localparam int FLAG_BIT = 31;

    // Word offsets decoded by the register interface
    typedef enum logic [1:0] {
        OFS_LIMIT      = 2'd0,
        OFS_COUNT      = 2'd1,
        OFS_LIMIT_KEEP = 2'd2,
        OFS_UNMAPPED   = 2'd3
    } ofs_e;

    // Per-cycle register operations derived from the strobes
    typedef struct packed {
        logic wr_limit;   // offset 0 write: new limit, restart count
        logic wr_keep;    // offset 2 write: new limit, count runs on
        logic rd_ack;     // offset 0 read: acknowledge
        logic rd_count;   // offset 1 read
        logic rd_zero;    // unmapped read
    } reg_ops_t;

    function automatic ofs_e classify(input logic [7:0] word_addr);
        case (word_addr)
            8'd0:    classify = OFS_LIMIT;
            8'd1:    classify = OFS_COUNT;
            8'd2:    classify = OFS_LIMIT_KEEP;
            default: classify = OFS_UNMAPPED;
        endcase
    endfunction

endpackage

// File: rtl/lmt_regif.sv
module lmt_regif
    import lmt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] lim_word,
    input  logic [WORD_W-1:0] cnt_word,
    output reg_ops_t          ops,
    output logic [WORD_W-1:0] rdata
);

    logic [7:0] addr_ext;
    ofs_e       ofs;

    always_comb begin
        addr_ext = 8'(addr);
        ofs      = classify(addr_ext);
        if (ADDR_W > 8 && (addr >> 8) != '0) begin
            ofs = OFS_UNMAPPED;
        end
    end

    always_comb begin
        ops          = '0;
        ops.wr_limit = wr_en && (ofs == OFS_LIMIT);
        ops.wr_keep  = wr_en && (ofs == OFS_LIMIT_KEEP);
        ops.rd_ack   = rd_en && (ofs == OFS_LIMIT);
        ops.rd_count = rd_en && (ofs == OFS_COUNT);
        ops.rd_zero  = rd_en && (ofs == OFS_UNMAPPED || ofs == OFS_LIMIT_KEEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (1'b1)
                ops.rd_ack:   rdata <= lim_word;
                ops.rd_count: rdata <= cnt_word;
                default:      rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/lmt_core.sv
module lmt_core #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             wr_limit,
    input  logic             wr_keep,
    input  logic [CNT_W-1:0] wr_field,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] lim,
    output logic             match_ev
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] eff_lim;
    logic             hit;
    logic             free_run;

    always_comb begin
        free_run = (lim == '0);
        eff_lim  = free_run ? TOP : lim;
        nxt      = cnt + 1'b1;
        hit      = tick_en && (nxt == eff_lim);
        match_ev = hit && !free_run && !wr_limit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_limit) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= hit ? '0 : nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lim <= '0;
        end else if (wr_limit || wr_keep) begin
            lim <= wr_field;
        end
    end

endmodule

// File: rtl/lmt_flags.sv
module lmt_flags (
    input  logic clk,
    input  logic rst,
    input  logic match_ev,
    input  logic ack,
    input  logic wr_limit,
    output logic reached,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reached <= 1'b0;
        end else if (match_ev) begin
            reached <= 1'b1;
        end else if (ack) begin
            reached <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (match_ev) begin
            irq <= 1'b1;
        end else if (ack || wr_limit) begin
            irq <= 1'b0;
        end
    end

    // R11
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> reached);

endmodule

// File: rtl/limit_match_timer.sv
module limit_match_timer
    import lmt_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int CNT_W   = 22,
    parameter int CNT_LSB = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);

    localparam int FIELD_MSB = CNT_LSB + CNT_W - 1;

    reg_ops_t         ops;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             match_ev;
    logic             reached;
    logic [WORD_W-1:0] lim_word;
    logic [WORD_W-1:0] cnt_word;

    generate
        if (FIELD_MSB >= FLAG_BIT) begin : g_bad_field
            initial $error("count field overlaps the reached flag");
        end
    endgenerate

    always_comb begin
        lim_word = '0;
        lim_word[CNT_LSB +: CNT_W] = lim;
        cnt_word = '0;
        cnt_word[CNT_LSB +: CNT_W] = cnt;
        cnt_word[FLAG_BIT] = reached;
    end

    lmt_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .lim_word (lim_word),
        .cnt_word (cnt_word),
        .ops      (ops),
        .rdata    (rdata)
    );

    lmt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .wr_limit (ops.wr_limit),
        .wr_keep  (ops.wr_keep),
        .wr_field (wdata[CNT_LSB +: CNT_W]),
        .cnt      (cnt),
        .lim      (lim),
        .match_ev (match_ev)
    );

    lmt_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .match_ev (match_ev),
        .ack      (ops.rd_ack),
        .wr_limit (ops.wr_limit),
        .reached  (reached),
        .irq      (irq)
    );

    // R4
    free_run_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(lim) != '0);

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        ops.wr_limit |=> (cnt == '0 && !irq));

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ops.rd_ack && !match_ev) |=> (!reached && !irq));

    // R2
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !ops.wr_limit) |=> $stable(cnt));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ops.rd_zero |=> rdata == '0);

endmodule

// File: tb/limit_match_timer_tb.sv
module limit_match_timer_tb;

    localparam int CW   = 6;
    localparam int TOPV = (1 << CW) - 1;
    localparam logic [31:0] FLAG = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    limit_match_timer #(.ADDR_W(3), .CNT_W(CW), .CNT_LSB(9)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] fld(input int v);
        return 32'(v) << 9;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 3'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 3'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'b0);
        rd(0, d); chk("R1 limit", d, 32'b0);
        rd(1, d); chk("R1 count", d, 32'b0);

        // R2 count position, hold without tick; R10 data held
        ticks(5);
        rd(1, d); chk("R2 count after 5 ticks", d, fld(5));
        repeat (4) @(negedge clk);
        chk("R10 rdata held", rdata, fld(5));
        rd(1, d); chk("R2 hold without tick", d, fld(5));

        // R4 free-run wrap, no flag, no irq
        ticks(TOPV - 1 - 5);
        rd(1, d); chk("R4 at top-1", d, fld(TOPV - 1));
        ticks(1);
        rd(1, d); chk("R4 wrapped", d, 32'b0);
        chk("R4 no irq", {31'b0, irq}, 32'b0);

        // R3/R6/R11 sweep every non-zero limit
        for (int l = 1; l <= TOPV; l++) begin
            wr(0, fld(l));
            rd(0, d); chk("R6 limit readback", d, fld(l));
            ticks(l - 1);
            rd(1, d); chk("R3 before match", d, fld(l - 1));
            chk("R3 no irq yet", {31'b0, irq}, 32'b0);
            ticks(1);
            chk("R3 irq at match", {31'b0, irq}, 32'b1);
            rd(1, d); chk("R3 count zero, flag set", d, FLAG);
            chk("R11 irq held", {31'b0, irq}, 32'b1);
            rd(0, d); chk("R6 ack read", d, fld(l));
            chk("R6 irq dropped", {31'b0, irq}, 32'b0);
            rd(1, d); chk("R6 flag cleared", d, 32'b0);
        end

        // R5 mask, restart, flag kept, irq dropped
        wr(0, fld(4)); ticks(4);
        chk("R5 irq before write", {31'b0, irq}, 32'b1);
        ticks(2);
        wr(0, 32'hFFFF_FFFF);
        chk("R5 irq dropped by write", {31'b0, irq}, 32'b0);
        rd(1, d); chk("R5 restart keeps flag", d, FLAG);
        rd(0, d); chk("R5 masked limit", d, fld(TOPV));

        // R7 writes to offset 1 ignored
        ticks(7);
        wr(1, 32'h1234_5678);
        rd(1, d); chk("R7 write ignored", d, fld(7));

        // R9 unmapped
        rd(5, d); chk("R9 unmapped read", d, 32'b0);
        wr(6, fld(3));
        rd(0, d); chk("R9 unmapped write", d, fld(TOPV));

        // R8 limit change above count
        wr(0, fld(10)); ticks(4);
        wr(2, fld(20));
        rd(1, d); chk("R8 count kept", d, fld(4));
        ticks(15);
        rd(1, d); chk("R8 before new match", d, fld(19));
        ticks(1);
        chk("R8 irq at new limit", {31'b0, irq}, 32'b1);
        rd(0, d); chk("R8 limit value", d, fld(20));

        // R8 limit change below count: runs to top, wraps
        wr(0, fld(30)); ticks(10);
        wr(2, fld(5));
        ticks(TOPV - 10);
        rd(1, d); chk("R8 ran to top", d, fld(TOPV));
        ticks(1);
        rd(1, d); chk("R8 wrap no match", d, 32'b0);
        chk("R8 no irq at wrap", {31'b0, irq}, 32'b0);
        ticks(5);
        chk("R8 match below", {31'b0, irq}, 32'b1);

        // R6 ack colliding with a match
        rd(0, d);
        wr(0, fld(3)); ticks(2);
        @(negedge clk);
        addr = 3'd0; rd_en = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; tick_en = 1'b0;
        chk("R6 collide read data", rdata, fld(3));
        chk("R6 collide irq kept", {31'b0, irq}, 32'b1);
        rd(1, d); chk("R6 collide flag kept", d, FLAG);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule